// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one burst request (a start byte address, an 8-bit length code, a 3-bit size code and a 2-bit burst kind) into the byte address of every beat of that burst. A load strobe captures the request. The first beat address appears on the next cycle. After that, every pulse of the step strobe means one beat was accepted elsewhere, and the address moves on to the following beat. A last-beat flag marks the final beat of the burst.

At load time the block also checks the burst against the length, alignment, size and 4KB page rules. It raises an illegal flag that stays set for the whole burst. A flagged burst still produces its beat addresses, so the logic around the block decides what to do with it. The block moves no data and drives no channel handshakes.

Top module: `burst_addr_gen`

## Requirements
- R1: A load strobe sampled high places the start address on the beat address output in the next cycle and begins a new burst. Load takes priority over a step strobe in the same cycle.
- R2: A burst has length code + 1 beats. The last flag is high exactly while the final beat is shown, and a step accepted on the final beat ends the burst.
- R3: Kind code 00 (fixed) keeps the beat address equal to the start address for every beat.
- R4: Kind code 01 (incrementing) adds 2^size bytes to the address on every accepted step.
- R5: Kind code 10 (wrapping) uses a window of (beats × 2^size) bytes, aligned to its own size. When the incremented address reaches the top of the window, the address returns to the window base.
- R6: A fixed burst with more than 16 beats is illegal. A wrapping burst is illegal unless its length code is 1, 3, 7 or 15.
- R7: An incrementing burst is illegal when the low 12 bits of the start address plus beats × 2^size exceed 4096.
- R8: Kind code 11 is illegal. A size code above log2 of the data bus width in bytes (2 for the default 32-bit bus) is illegal. A wrapping burst whose start address is not aligned to 2^size is illegal.
- R9: The illegal flag is computed at load, held until the next load, and does not stop address generation.
- R10: Once the final beat has been accepted, step strobes are ignored until the next load: the last flag stays low and the address holds the final beat address.
- R11: After reset the address is 0 and both flags are low. Step strobes before the first load change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture a new burst request |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| len_i | input | 8 | Length code (beats − 1) |
| size_i | input | 3 | Size code, 2^size bytes per beat |
| kind_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| step_i | input | 1 | One beat accepted |
| beat_addr_o | output | ADDR_W | Byte address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| illegal_o | output | 1 | Loaded burst breaks a burst rule |

## Verification
The bench drives incrementing bursts with several sizes, including a 256-beat burst that ends exactly on a 4KB page edge. This separates a correct page check from an off-by-one check. Wrapping bursts start mid-window and at odd byte offsets, which shows whether the fold goes to the aligned window base rather than to the start address. Fixed bursts, reserved kinds, oversize codes, disallowed lengths and unaligned wrap starts exercise each illegal cause separately. Irregular step stalls, together with steps applied after the final beat, confirm that the address moves only on accepted beats.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  localparam int PAGE_BITS   = 12;
  localparam int FIX_MAX_LEN = 15;
endpackage

// File: rtl/bag_rules.sv
module bag_rules
  import bag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int MAX_SIZE = 2
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  burst_kind_e       kind_i,
  output logic              bad_o
);
  localparam int SPAN_W = LEN_W + 10;

  function automatic logic len_fits(input burst_kind_e k, input logic [LEN_W-1:0] l);
    case (k)
      BK_FIXED: len_fits = (l <= LEN_W'(FIX_MAX_LEN));
      BK_INCR:  len_fits = 1'b1;
      BK_WRAP:  len_fits = (l == LEN_W'(1)) || (l == LEN_W'(3)) ||
                           (l == LEN_W'(7)) || (l == LEN_W'(15));
      default:  len_fits = 1'b0;
    endcase
  endfunction

  function automatic logic stays_in_page(input logic [PAGE_BITS-1:0] off,
                                         input logic [LEN_W-1:0] l,
                                         input logic [2:0] s);
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] stop;
    span = (SPAN_W'(l) + SPAN_W'(1)) << s;
    stop = SPAN_W'(off) + span;
    stays_in_page = (stop <= SPAN_W'(1 << PAGE_BITS));
  endfunction

  logic size_ok, align_ok, page_ok, len_ok;
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    low_mask = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    size_ok  = (size_i <= 3'(MAX_SIZE));
    len_ok   = len_fits(kind_i, len_i);
    align_ok = (kind_i != BK_WRAP) || ((start_i & low_mask) == '0);
    page_ok  = (kind_i != BK_INCR) ||
               stays_in_page(start_i[PAGE_BITS-1:0], len_i, size_i);
    bad_o    = !(size_ok && len_ok && align_ok && page_ok);
  end
endmodule

// File: rtl/bag_counter.sv
module bag_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             live_o,
  output logic             last_o,
  output logic             move_o,
  output logic             end_o
);
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             live_q;
  logic             on_final;

  assign on_final = (cnt_q == len_q);
  assign move_o   = step_i && live_q && !load_i && !on_final;
  assign end_o    = step_i && live_q && !load_i && on_final;
  assign live_o   = live_q;
  assign last_o   = live_q && on_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      live_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      len_q  <= len_i;
      live_q <= 1'b1;
    end else if (end_o) begin
      live_q <= 1'b0;
    end else if (move_o) begin
      cnt_q  <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/bag_addr_unit.sv
module bag_addr_unit
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              move_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  burst_kind_e       kind_i,
  output logic [ADDR_W-1:0] addr_o,
  output burst_kind_e       kind_o,
  output logic [2:0]        size_o,
  output logic [ADDR_W-1:0] mask_o
);
  function automatic logic [ADDR_W-1:0] window_mask(input logic [LEN_W-1:0] l,
                                                    input logic [2:0] s);
    window_mask = ((ADDR_W'(l) + ADDR_W'(1)) << s) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] next_beat(input logic [ADDR_W-1:0] a,
                                                  input burst_kind_e k,
                                                  input logic [2:0] s,
                                                  input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] bumped;
    bumped = a + (ADDR_W'(1) << s);
    case (k)
      BK_FIXED: next_beat = a;
      BK_WRAP:  next_beat = (a & ~m) | (bumped & m);
      default:  next_beat = bumped;
    endcase
  endfunction

  logic [ADDR_W-1:0] addr_q, mask_q;
  burst_kind_e       kind_q;
  logic [2:0]        size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      kind_q <= BK_FIXED;
      size_q <= '0;
    end else if (load_i) begin
      addr_q <= start_i;
      mask_q <= window_mask(len_i, size_i);
      kind_q <= kind_i;
      size_q <= size_i;
    end else if (move_i) begin
      addr_q <= next_beat(addr_q, kind_q, size_q, mask_q);
    end
  end

  assign addr_o = addr_q;
  assign kind_o = kind_q;
  assign size_o = size_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [7:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        kind_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              last_o,
  output logic              illegal_o
);
  localparam int LEN_W    = 8;
  localparam int MAX_SIZE = $clog2(DATA_W / 8);

  burst_kind_e       kind_in;
  burst_kind_e       cur_kind_w;
  logic [2:0]        cur_size_w;
  logic [ADDR_W-1:0] cur_mask_w;
  logic              live_w, move_w, end_w, bad_w;
  logic              illegal_q;

  assign kind_in = burst_kind_e'(kind_i);

  bag_rules #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_SIZE(MAX_SIZE)) u_rules (
    .start_i (start_addr_i),
    .len_i   (len_i),
    .size_i  (size_i),
    .kind_i  (kind_in),
    .bad_o   (bad_w)
  );

  bag_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .step_i (step_i),
    .len_i  (len_i),
    .live_o (live_w),
    .last_o (last_o),
    .move_o (move_w),
    .end_o  (end_w)
  );

  bag_addr_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .move_i  (move_w),
    .start_i (start_addr_i),
    .len_i   (len_i),
    .size_i  (size_i),
    .kind_i  (kind_in),
    .addr_o  (beat_addr_o),
    .kind_o  (cur_kind_w),
    .size_o  (cur_size_w),
    .mask_o  (cur_mask_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      illegal_q <= 1'b0;
    else if (load_i) illegal_q <= bad_w;
  end

  assign illegal_o = illegal_q;
endmodule

// File: rtl/bag_checker.sv
module bag_checker
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic              last_o,
  input logic              illegal_o,
  input logic              live_w,
  input logic              move_w,
  input logic              end_w,
  input burst_kind_e       cur_kind_w,
  input logic [2:0]        cur_size_w,
  input logic [ADDR_W-1:0] cur_mask_w
);
  a_r1_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_addr_o == $past(start_addr_i)) && live_w);

  a_r2_final_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && step_i && !load_i) |=> (!last_o && !live_w));

  a_r2_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    end_w |-> last_o);

  a_r3_fixed_still: assert property (@(posedge clk) disable iff (!rst_n)
    (move_w && cur_kind_w == BK_FIXED) |=> $stable(beat_addr_o));

  a_r4_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (move_w && cur_kind_w == BK_INCR) |=>
      (beat_addr_o == $past(beat_addr_o) + (ADDR_W'(1) << $past(cur_size_w))));

  a_r5_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
    (move_w && cur_kind_w == BK_WRAP) |=>
      (((beat_addr_o ^ $past(beat_addr_o)) & ~$past(cur_mask_w)) == '0));

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(illegal_o));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_w && !load_i) |=> ($stable(beat_addr_o) && !last_o));
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .step_i       (step_i),
  .start_addr_i (start_addr_i),
  .beat_addr_o  (beat_addr_o),
  .last_o       (last_o),
  .illegal_o    (illegal_o),
  .live_w       (live_w),
  .move_w       (move_w),
  .end_w        (end_w),
  .cur_kind_w   (cur_kind_w),
  .cur_size_w   (cur_size_w),
  .cur_mask_w   (cur_mask_w)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] start = '0;
  logic [7:0]  len = '0;
  logic [2:0]  size = '0;
  logic [1:0]  kind = '0;
  logic        step = 1'b0;
  logic [31:0] addr;
  logic        last, ill;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] a;
    logic        lst;
    logic        il;
    logic        chk_a;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load), .start_addr_i(start),
    .len_i(len), .size_i(size), .kind_i(kind), .step_i(step),
    .beat_addr_o(addr), .last_o(last), .illegal_o(ill)
  );

  // Reference: beat k lies at an offset within its window (wrap) or a fixed distance from start
  function automatic logic [31:0] ref_addr(input logic [31:0] st, input int ln,
                                           input int sz, input int kd, input int k);
    longint bytes = longint'(1) << sz;
    longint win, base;
    case (kd)
      0: ref_addr = st;
      2: begin
        win  = (ln + 1) * bytes;
        base = st - (st % win);
        ref_addr = 32'(base + ((st - base) + k * bytes) % win);
      end
      default: ref_addr = 32'(st + k * bytes);
    endcase
  endfunction

  function automatic logic ref_bad(input logic [31:0] st, input int ln,
                                   input int sz, input int kd);
    ref_bad = 1'b0;
    if (sz > 2) ref_bad = 1'b1;
    if (kd == 3) ref_bad = 1'b1;
    if (kd == 0 && ln + 1 > 16) ref_bad = 1'b1;
    if (kd == 2 && !(ln + 1 == 2 || ln + 1 == 4 || ln + 1 == 8 || ln + 1 == 16))
      ref_bad = 1'b1;
    if (kd == 2 && (st % (1 << sz)) != 0) ref_bad = 1'b1;
    if (kd == 1 && (int'(st[11:0]) + (ln + 1) * (1 << sz)) > 4096) ref_bad = 1'b1;
  endfunction

  task automatic check_now(input string tag, input logic [31:0] ea,
                           input logic el, input logic ei);
    total++;
    if (addr !== ea || last !== el || ill !== ei) begin
      bad++;
      $display("FAIL %s: addr=%h last=%b ill=%b expected addr=%h last=%b ill=%b",
               tag, addr, last, ill, ea, el, ei);
    end
  endtask

  // Monitor: pops one expected item per cycle while bursts run
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if ((e.chk_a && addr !== e.a) || last !== e.lst || ill !== e.il) begin
        bad++;
        $display("FAIL %s: addr=%h last=%b ill=%b expected addr=%h last=%b ill=%b",
                 e.tag, addr, last, ill, e.a, e.lst, e.il);
      end
    end
  end

  // Driver: loads with step held high (R1 priority), stalls irregularly,
  // then keeps stepping after the end (R10)
  task automatic run_burst(input logic [31:0] st, input int ln, input int sz,
                           input int kd, input string tg);
    int  beats = ln + 1;
    logic il = ref_bad(st, ln, sz, kd);
    logic ca = (sz <= 2) && (kd == 0 || kd == 1 || !il);
    int  cur = 0;
    bit  done = 0;
    int  tail = 0;
    int  cyc = 0;
    @(posedge clk); #2;
    load = 1'b1; step = 1'b1;
    start = st; len = 8'(ln); size = 3'(sz); kind = 2'(kd);
    while (tail < 2) begin
      exp_t e;
      @(posedge clk); #2;
      load = 1'b0;
      if (done) begin
        e = '{ref_addr(st, ln, sz, kd, beats - 1), 1'b0, il, ca, {"R10 ", tg}};
        tail++;
        step = 1'b1;
      end else begin
        e = '{ref_addr(st, ln, sz, kd, cur), (cur == beats - 1), il, ca, {"R2 ", tg}};
        step = ((cyc % 3) != 2);
        if (step) begin
          if (cur == beats - 1) done = 1;
          else cur++;
        end
      end
      q.push_back(e);
      cyc++;
    end
    step = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    check_now("R11 reset", 32'h0, 1'b0, 1'b0);
    step = 1'b1;
    repeat (2) @(negedge clk);
    check_now("R11 step before load", 32'h0, 1'b0, 1'b0);
    step = 1'b0;

    run_burst(32'h0000_0100, 3,   2, 1, "R1 R4");
    run_burst(32'h0000_2002, 5,   1, 0, "R3");
    run_burst(32'h0000_1008, 3,   2, 2, "R5");
    run_burst(32'h0000_0034, 15,  2, 2, "R5 R6");
    run_burst(32'h0000_0007, 1,   0, 2, "R5");
    run_burst(32'h0000_0F00, 255, 0, 1, "R7 R4");
    run_burst(32'h0000_0FFC, 1,   2, 1, "R7 R9");
    run_burst(32'h0000_0ABC, 0,   2, 1, "R2 R4");
    run_burst(32'h0000_0040, 16,  0, 0, "R6 R9");
    run_burst(32'h0000_0040, 15,  0, 0, "R6 R3");
    run_burst(32'h0000_0040, 2,   2, 2, "R6");
    run_burst(32'h0000_1001, 3,   2, 2, "R8 align");
    run_burst(32'h0000_0200, 3,   2, 3, "R8 reserved");
    run_burst(32'h0000_0200, 1,   3, 1, "R8 size");
    run_burst(32'h0000_0300, 2,   1, 1, "R9 cleared R4");

    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule